// File: doc/BRIEF.md
# Power-Up Battery Check Sequencer

This block decides, once after every reset, whether the battery behind a byte-wide non-volatile RAM is still healthy. It relies on one behaviour of such memories: when the backup cell is weak, the memory drops the first write that arrives after power returns. The sequencer asks for the shared memory bus and waits for a grant. It then reads one scratch location, writes the bitwise complement of that byte and reads the location again. If the second read returns the complement, the write was accepted, so the battery is good and the original byte is written back. If the original byte comes back, the write was dropped and the battery is reported bad.

The top level contains the sequencer, a two-way bus multiplexer and a behavioural model of the battery-backed memory. The multiplexer passes a host port through to the memory whenever the sequencer does not hold the granted bus. The model is 2 KiB by default. The eight highest addresses are its clock registers and must never be used as the scratch location. Its `battery_low` input is sampled during reset. When it is high, the next write attempt is discarded, whichever master issues it.

The states and transitions of the state machine are as follows.
- Reset leaves the machine in IDLE, which always moves to REQUEST.
- REQUEST waits for `bus_gnt` and then moves to READ_ORIG.
- The next states follow one cycle each: CAPTURE_ORIG, WRITE_CPL, READ_BACK, then COMPARE.
- COMPARE goes to RESTORE on a match and straight to REPORT on a mismatch.
- RESTORE moves to REPORT.
- REPORT pulses `chk_done` and moves to HALT.
- HALT is left only by reset.

Top module: `nvbat_probe`

## Requirements
- R1: After reset is released, `bus_req` goes high. The sequencer makes no memory access while `bus_gnt` is low.
- R2: Once granted, the sequencer reads the scratch byte, writes its bitwise complement and reads it back. A read-back equal to the complement sets `battery_ok` to 1.
- R3: When the battery is good, the original byte is written back, so a later host read of the scratch address returns the value held before the check.
- R4: When `battery_low` is 1 during reset, the first write after reset is discarded. The check then reports `battery_ok` = 0 and leaves the scratch byte unchanged.
- R5: From the cycle after grant, `bus_req` stays high for exactly 6 cycles when the battery is good and exactly 5 when it is bad, because no restore write is issued on the bad path.
- R6: Only the first write after reset is discarded. A later host write to the scratch address is stored.
- R7: `chk_done` is a single-cycle pulse in the cycle after `bus_req` falls. It occurs exactly once per reset, and `battery_ok` holds its value from then until the next reset.
- R8: The scratch address never falls within the eight clock registers at the top of the address space (0x7F8 to 0x7FF by default).
- R9: While the sequencer does not own the granted bus, the host port drives the memory. A host read returns its data on `host_rdata` one clock edge after the request.
- R10: While reset is held, `bus_req`, `chk_done` and `battery_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also restarts the memory model's first-write blocking |
| battery_low | input | 1 | Memory model: weak backup cell, sampled during reset |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_req | output | 1 | Sequencer requests the memory bus |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data from the memory |
| chk_done | output | 1 | One-cycle pulse when the check has finished |
| battery_ok | output | 1 | Check result; valid from `chk_done` until reset |

## Verification
The bench sweeps every possible scratch byte value with the battery both good and low. It preloads the byte through the host port and applies a warm reset, so the memory keeps its contents across the check. A design that restored the byte on the bad path, or skipped the restore on the good path, shows up in the exact count of request cycles and in the value the host reads afterwards. A design that wrote the original value instead of its complement would look good for every value when the battery is low, and the sweep catches that. A memory model that dropped every write, rather than only the first, is caught by a host write made after the check.

// File: rtl/nvbat_pkg.sv
package nvbat_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD1,
        ST_CAP1,
        ST_WRC,
        ST_RD2,
        ST_CAP2,
        ST_REST,
        ST_DONE,
        ST_HALT
    } probe_state_t;

    localparam int unsigned CLK_REG_COUNT = 8;

endpackage

// File: rtl/nvbat_store.sv
module nvbat_store #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              battery_low,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic              armed_q;

    // first write after reset is dropped when the backup cell is weak
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= battery_low;
        end else if (en && we) begin
            armed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (en && we && !armed_q) begin
            cells[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= cells[addr];
        end
    end

endmodule

// File: rtl/nvbat_busmux.sv
module nvbat_busmux #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              seq_owns,
    input  logic              seq_en,
    input  logic              seq_we,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [DATA_W-1:0] seq_wdata,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    always_comb begin
        if (seq_owns) begin
            mem_en    = seq_en;
            mem_we    = seq_we;
            mem_addr  = seq_addr;
            mem_wdata = seq_wdata;
        end else begin
            mem_en    = host_en;
            mem_we    = host_we;
            mem_addr  = host_addr;
            mem_wdata = host_wdata;
        end
    end

endmodule

// File: rtl/nvbat_seq.sv
module nvbat_seq
    import nvbat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 11'h123
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] rd_data,
    output logic              bus_req,
    output logic              acc_en,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              chk_done,
    output logic              battery_ok,
    output probe_state_t      state_o
);
    probe_state_t      state_q, state_d;
    logic [DATA_W-1:0] orig_q;
    logic              ok_q;
    logic              match;

    assign match = (rd_data == ~orig_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_REQ;
            ST_REQ:  state_d = bus_gnt ? ST_RD1 : ST_REQ;
            ST_RD1:  state_d = ST_CAP1;
            ST_CAP1: state_d = ST_WRC;
            ST_WRC:  state_d = ST_RD2;
            ST_RD2:  state_d = ST_CAP2;
            ST_CAP2: state_d = match ? ST_REST : ST_DONE;
            ST_REST: state_d = ST_DONE;
            ST_DONE: state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    // captured byte and verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            orig_q <= '0;
            ok_q   <= 1'b0;
        end else begin
            if (state_q == ST_CAP1) begin
                orig_q <= rd_data;
            end
            if (state_q == ST_CAP2) begin
                ok_q <= match;
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        acc_en    = 1'b0;
        acc_we    = 1'b0;
        acc_addr  = TEST_ADDR;
        acc_wdata = orig_q;
        chk_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  bus_req = 1'b1;
            ST_RD1: begin
                bus_req = 1'b1;
                acc_en  = 1'b1;
            end
            ST_CAP1: bus_req = 1'b1;
            ST_WRC: begin
                bus_req   = 1'b1;
                acc_en    = 1'b1;
                acc_we    = 1'b1;
                acc_wdata = ~orig_q;
            end
            ST_RD2: begin
                bus_req = 1'b1;
                acc_en  = 1'b1;
            end
            ST_CAP2: bus_req = 1'b1;
            ST_REST: begin
                bus_req = 1'b1;
                acc_en  = 1'b1;
                acc_we  = 1'b1;
            end
            ST_DONE: chk_done = 1'b1;
            ST_HALT: ;
            default: ;
        endcase
    end

    assign battery_ok = ok_q;
    assign state_o    = state_q;

endmodule

// File: rtl/nvbat_probe.sv
module nvbat_probe
    import nvbat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] TEST_ADDR = 11'h123
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              battery_low,
    input  logic              bus_gnt,
    output logic              bus_req,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              chk_done,
    output logic              battery_ok
);
    logic              seq_en, seq_we, seq_owns;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] seq_wdata;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    probe_state_t      seq_state;

    assign seq_owns   = bus_req & bus_gnt;
    assign host_rdata = mem_rdata;

    nvbat_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TEST_ADDR(TEST_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .rd_data(mem_rdata),
        .bus_req(bus_req), .acc_en(seq_en), .acc_we(seq_we),
        .acc_addr(seq_addr), .acc_wdata(seq_wdata),
        .chk_done(chk_done), .battery_ok(battery_ok), .state_o(seq_state)
    );

    nvbat_busmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .seq_owns(seq_owns), .seq_en(seq_en), .seq_we(seq_we),
        .seq_addr(seq_addr), .seq_wdata(seq_wdata),
        .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    nvbat_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .battery_low(battery_low),
        .en(mem_en), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

endmodule

// File: rtl/nvbat_probe_chk.sv
module nvbat_probe_chk
    import nvbat_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              seq_en,
    input logic [ADDR_W-1:0] seq_addr,
    input logic              chk_done,
    input logic              battery_ok,
    input probe_state_t      seq_state
);
    localparam int unsigned CLK_BASE = (1 << ADDR_W) - CLK_REG_COUNT;

    assert_no_access_ungranted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seq_en |-> bus_gnt);

    assert_no_early_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state inside {ST_REQ, ST_RD1, ST_CAP1, ST_WRC, ST_RD2}) |-> !battery_ok);

    assert_req_falls_into_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> chk_done);

    assert_done_bus_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> !bus_req);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> !chk_done);

    assert_verdict_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_HALT) |=> $stable(battery_ok));

    assert_addr_outside_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_en |-> (32'(seq_addr) < CLK_BASE));

endmodule

bind nvbat_probe nvbat_probe_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .seq_en(seq_en), .seq_addr(seq_addr), .chk_done(chk_done),
    .battery_ok(battery_ok), .seq_state(seq_state)
);

// File: tb/sim_nvbat_probe.sv
`timescale 1ns/1ps
module sim_nvbat_probe;
    localparam int unsigned AW = 11;
    localparam int unsigned DW = 8;
    localparam logic [AW-1:0] TADDR = 11'h123;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          battery_low = 1'b0;
    logic          bus_gnt = 1'b0;
    logic          bus_req;
    logic          host_en = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          chk_done;
    logic          battery_ok;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nvbat_probe #(.ADDR_W(AW), .DATA_W(DW), .TEST_ADDR(TADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .battery_low(battery_low),
        .bus_gnt(bus_gnt), .bus_req(bus_req),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .chk_done(chk_done), .battery_ok(battery_ok)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic do_reset(input logic low);
        @(negedge clk);
        rst_n = 1'b0;
        battery_low = low;
        bus_gnt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!bus_req && !chk_done && !battery_ok, "R10 reset outputs",
              {bus_req, chk_done, battery_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [DW-1:0] d);
        host_en = 1'b1; host_we = 1'b1; host_addr = TADDR; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_rd(output logic [DW-1:0] d);
        host_en = 1'b1; host_we = 1'b0; host_addr = TADDR;
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic run_case(input logic [DW-1:0] v, input logic low);
        int req_cnt = 0;
        int done_cnt = 0;
        logic ok_at_done = 1'b0;
        logic [DW-1:0] rb;
        do_reset(1'b0);
        host_wr(v);
        do_reset(low);
        // R1: requesting, nothing happens without grant
        check(bus_req && !chk_done, "R1 request pending without grant", bus_req, 1);
        bus_gnt = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_req && bus_gnt) req_cnt++;
            if (chk_done) begin
                done_cnt++;
                ok_at_done = battery_ok;
                check(!bus_req, "R7 bus released at done", bus_req, 0);
            end
            if (done_cnt > 0 && !chk_done)
                check(battery_ok == ok_at_done, "R7 verdict stable", battery_ok, ok_at_done);
        end
        bus_gnt = 1'b0;
        check(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
        if (low)
            check(ok_at_done == 1'b0, "R4 low battery reported bad", ok_at_done, 0);
        else
            check(ok_at_done == 1'b1, "R2 good battery reported ok", ok_at_done, 1);
        check(req_cnt == (low ? 5 : 6), "R5 bus hold length", req_cnt, low ? 5 : 6);
        host_rd(rb);
        check(rb == v, low ? "R4 byte unchanged" : "R3 byte restored", rb, v);
        host_wr(~v);
        host_rd(rb);
        check(rb == ~v, "R6 later write stored / R9 host read", rb, 32'(~v) & 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int lv = 0; lv < 2; lv++) begin
            for (int v = 0; v < 256; v++) begin
                run_case(v[DW-1:0], lv[0]);
            end
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule